// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block interprets the write cycles arriving at a one-time-programmable memory's command port. Each write carries an address and a data word. The block watches for a two-write unlock key, followed by a command byte. It recognises four commands: single-word program, identification, return-to-read, and a hand-over for the separate multi-word sequencer. A program command ends with a fourth write that carries the target address and word. That write launches the program engine, and the launch carries the latched address together with a word that has been masked so it can only clear bits.

While the engine works, or after a failure, reads return a status byte instead of array data. When the block is in identification mode, reads return two fixed ID words. A supply-good input gates every command. If the high-voltage supply is absent, writes do nothing, and a partly entered sequence is dropped.

Top module: `ucd_decoder`

## Requirements
- R1: After reset the mode output is 0 (read), no start, abort or hand-over pulse is issued, and reads return the array word unchanged.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then any address/data issue a one-cycle start carrying that address and the word (data AND stored word). Mode becomes 2 (program), and returns to 0 once the engine's busy has risen and fallen.
- R3: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 set mode 1 (identify). In identify mode, reads with address bits [1:0]=00 return 0x0020, reads with [1:0]=01 return 0x888E, and reads with bit 1 set return 0.
- R4: A single write of 0xF0 to any address, or the unlock pair followed by 0xF0, sets mode 0. This is accepted between the writes of a sequence and clears the partial sequence.
- R5: A write that does not match the next expected step drops the sequence, so a following write starts nothing.
- R6: While the supply-good input is low, writes issue no command, leave the mode unchanged and drop any partial sequence.
- R7: In identify mode, unlock-prefixed program, identify and hand-over codes are ignored; only reset leaves the mode.
- R8: In program mode all writes, reset included, are ignored. Reads return status: bit 7 is the inverse of bit 7 of the start word, bit 6 flips after each read, the bits above 7 are 0, and bits 5 and 4 are 0 while no error exists.
- R9: If the requested word sets a bit the stored word has at 0, that bit stays 0 in the start word, and when the engine finishes the mode becomes 3 (error) with status bit 5 set.
- R10: In error mode, reads keep returning status and every command other than reset is ignored.
- R11: If supply-good falls during program mode, a one-cycle abort pulse is issued, mode becomes 3, and status bits 5 and 4 are set.
- R12: Decoding compares only address bits [10:0] and data bits [7:0]. The upper bits are ignored for commands but carried in the program start address and word.
- R13: The unlock pair followed by 0x20@0x555 in read mode gives a one-cycle hand-over pulse to the multi-word sequencer, and the mode stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| arr_wr_old | input | DATA_W | Stored array word at wr_addr |
| hv_ok | input | 1 | High-voltage supply present |
| eng_busy | input | 1 | Program engine running |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_rd_data | input | DATA_W | Stored array word at rd_addr |
| rd_data | output | DATA_W | Read result: array, ID word or status |
| mode | output | 2 | 0 read, 1 identify, 2 program, 3 error |
| prog_start | output | 1 | One-cycle engine launch |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched clear-only program word |
| prog_abort | output | 1 | One-cycle abort on supply loss |
| multi_handoff | output | 1 | One-cycle hand-over to multi-word sequencer |

## Verification
The bench builds the block with its default widths: a 21-bit address and a 16-bit word. At these widths, address bits 11 to 20 and data bits 8 to 15 exist, so the bench can place nonzero values there. This shows two things: command matching ignores those bits, and the program start still carries them. The 16-bit word also holds the full 0x888E device code, so the bench can confirm that status reads leave the upper byte at zero.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
    localparam int CMD_AW = 11;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [CMD_DW-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [CMD_DW-1:0] KEY_DATA_B = 8'h55;
    localparam logic [CMD_DW-1:0] OP_IDENT   = 8'h90;
    localparam logic [CMD_DW-1:0] OP_PROG    = 8'hA0;
    localparam logic [CMD_DW-1:0] OP_MULTI   = 8'h20;
    localparam logic [CMD_DW-1:0] OP_RESET   = 8'hF0;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_PROG  = 2'd2,
        MODE_ERR   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_KEY1 = 2'd1,
        SQ_KEY2 = 2'd2,
        SQ_ARM  = 2'd3
    } seq_e;
endpackage

// File: rtl/ucd_match.sv
module ucd_match
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit_key1,
    output logic              hit_key2,
    output logic              hit_ident,
    output logic              hit_prog,
    output logic              hit_multi,
    output logic              hit_reset
);
    logic [CMD_AW-1:0] a_low;
    logic [CMD_DW-1:0] d_low;
    logic              at_a;
    logic              at_b;

    assign a_low = addr[CMD_AW-1:0];
    assign d_low = data[CMD_DW-1:0];
    assign at_a  = (a_low == KEY_ADDR_A);
    assign at_b  = (a_low == KEY_ADDR_B);

    always_comb begin
        hit_key1  = at_a && (d_low == KEY_DATA_A);
        hit_key2  = at_b && (d_low == KEY_DATA_B);
        hit_ident = at_a && (d_low == OP_IDENT);
        hit_prog  = at_a && (d_low == OP_PROG);
        hit_multi = at_a && (d_low == OP_MULTI);
        hit_reset = (d_low == OP_RESET);
    end
endmodule

// File: rtl/ucd_readmux.sv
module ucd_readmux
    import ucd_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [15:0]     MFR_ID = 16'h0020,
    parameter logic [15:0]     DEV_ID = 16'h888E
) (
    input  mode_e             mode,
    input  logic [1:0]        id_sel,
    input  logic [DATA_W-1:0] arr_rd_data,
    input  logic              stat_poll,
    input  logic              stat_toggle,
    input  logic              stat_vpp,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDW = (DATA_W < 16) ? DATA_W : 16;

    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mfr_w;
    logic [DATA_W-1:0] dev_w;

    always_comb begin
        mfr_w = '0;
        dev_w = '0;
        mfr_w[IDW-1:0] = MFR_ID[IDW-1:0];
        dev_w[IDW-1:0] = DEV_ID[IDW-1:0];
    end

    always_comb begin
        status_w    = '0;
        status_w[7] = stat_poll;
        status_w[6] = stat_toggle;
        status_w[5] = (mode == MODE_ERR);
        status_w[4] = stat_vpp;
    end

    always_comb begin
        unique case (mode)
            MODE_READ:  rd_data = arr_rd_data;
            MODE_IDENT: rd_data = id_sel[1] ? '0 : (id_sel[0] ? dev_w : mfr_w);
            default:    rd_data = status_w;
        endcase
    end
endmodule

// File: rtl/ucd_decoder.sv
module ucd_decoder
    import ucd_pkg::*;
#(
    parameter int          ADDR_W = 21,
    parameter int          DATA_W = 16,
    parameter logic [15:0] MFR_ID = 16'h0020,
    parameter logic [15:0] DEV_ID = 16'h888E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] arr_wr_old,
    input  logic              hv_ok,
    input  logic              eng_busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mode,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              prog_abort,
    output logic              multi_handoff
);
    typedef struct packed {
        mode_e             mode;
        seq_e              seq;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic              conflict;
        logic              busy_seen;
        logic              vpp_err;
        logic              toggle;
        logic              start;
        logic              abort;
        logic              multi;
    } state_t;

    state_t st_d, st_q;

    logic hit_key1, hit_key2, hit_ident, hit_prog, hit_multi, hit_reset;

    ucd_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_match (
        .addr      (wr_addr),
        .data      (wr_data),
        .hit_key1  (hit_key1),
        .hit_key2  (hit_key2),
        .hit_ident (hit_ident),
        .hit_prog  (hit_prog),
        .hit_multi (hit_multi),
        .hit_reset (hit_reset)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.abort = 1'b0;
        st_d.multi = 1'b0;

        if (rd_en && (st_q.mode == MODE_PROG || st_q.mode == MODE_ERR)) begin
            st_d.toggle = ~st_q.toggle;
        end

        if (st_q.mode == MODE_PROG) begin
            if (!hv_ok) begin
                st_d.mode      = MODE_ERR;
                st_d.vpp_err   = 1'b1;
                st_d.abort     = 1'b1;
                st_d.busy_seen = 1'b0;
            end else if (eng_busy) begin
                st_d.busy_seen = 1'b1;
            end else if (st_q.busy_seen) begin
                st_d.mode      = st_q.conflict ? MODE_ERR : MODE_READ;
                st_d.busy_seen = 1'b0;
            end
        end else if (wr_en) begin
            if (!hv_ok) begin
                st_d.seq = SQ_IDLE;
            end else if (st_q.seq == SQ_ARM) begin
                st_d.seq       = SQ_IDLE;
                st_d.mode      = MODE_PROG;
                st_d.start     = 1'b1;
                st_d.paddr     = wr_addr;
                st_d.pdata     = wr_data & arr_wr_old;
                st_d.conflict  = |(wr_data & ~arr_wr_old);
                st_d.vpp_err   = 1'b0;
                st_d.toggle    = 1'b0;
                st_d.busy_seen = 1'b0;
            end else if (hit_reset) begin
                st_d.seq      = SQ_IDLE;
                st_d.mode     = MODE_READ;
                st_d.vpp_err  = 1'b0;
                st_d.conflict = 1'b0;
            end else begin
                unique case (st_q.seq)
                    SQ_IDLE: st_d.seq = hit_key1 ? SQ_KEY1 : SQ_IDLE;
                    SQ_KEY1: st_d.seq = hit_key2 ? SQ_KEY2 : SQ_IDLE;
                    default: begin
                        st_d.seq = SQ_IDLE;
                        if (st_q.mode == MODE_READ) begin
                            if (hit_ident) begin
                                st_d.mode = MODE_IDENT;
                            end else if (hit_prog) begin
                                st_d.seq = SQ_ARM;
                            end else if (hit_multi) begin
                                st_d.multi = 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_READ, seq: SQ_IDLE, paddr: '0, pdata: '0,
                      conflict: 1'b0, busy_seen: 1'b0, vpp_err: 1'b0,
                      toggle: 1'b0, start: 1'b0, abort: 1'b0, multi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    ucd_readmux #(
        .DATA_W (DATA_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_readmux (
        .mode        (st_q.mode),
        .id_sel      (rd_addr[1:0]),
        .arr_rd_data (arr_rd_data),
        .stat_poll   (~st_q.pdata[7]),
        .stat_toggle (st_q.toggle),
        .stat_vpp    (st_q.vpp_err),
        .rd_data     (rd_data)
    );

    assign mode          = st_q.mode;
    assign prog_start    = st_q.start;
    assign prog_addr     = st_q.paddr;
    assign prog_data     = st_q.pdata;
    assign prog_abort    = st_q.abort;
    assign multi_handoff = st_q.multi;

    // R2: a launch always follows a bus write in the previous cycle
    assert_start_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(wr_en));

    // R9: the launched word never sets a bit the stored word holds at 0
    assert_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> ((prog_data & ~$past(arr_wr_old)) == '0));

    assert_lowhv_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hv_ok && mode != MODE_PROG) |=> (!prog_start && mode == $past(mode)));

    assert_prog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PROG && hv_ok && eng_busy) |=> (mode == MODE_PROG));

    assert_err_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERR) |=> (mode == MODE_ERR || mode == MODE_READ));

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PROG && !hv_ok) |=> (mode == MODE_ERR && prog_abort));
endmodule

// File: tb/ucd_decoder_bench.sv
`timescale 1ns/1ps
module ucd_decoder_bench;
    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] arr_wr_old;
    logic          hv_ok = 1'b1;
    logic          eng_busy = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rd_data;
    logic [DW-1:0] rd_data;
    logic [1:0]    mode;
    logic          prog_start;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    logic          prog_abort;
    logic          multi_handoff;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    typedef struct {
        logic [DW-1:0] val;
        string         req;
    } rd_item_t;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         req;
    } st_item_t;

    rd_item_t rd_q[$];
    st_item_t st_q[$];

    always #2.5 clk = ~clk;

    assign arr_wr_old  = (wr_addr == 21'h00100) ? 16'hFF0F : 16'hFFFF;
    assign arr_rd_data = rd_addr[15:0] ^ 16'h5A5A;

    ucd_decoder u_ucd_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .arr_wr_old    (arr_wr_old),
        .hv_ok         (hv_ok),
        .eng_busy      (eng_busy),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .arr_rd_data   (arr_rd_data),
        .rd_data       (rd_data),
        .mode          (mode),
        .prog_start    (prog_start),
        .prog_addr     (prog_addr),
        .prog_data     (prog_data),
        .prog_abort    (prog_abort),
        .multi_handoff (multi_handoff)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: compares reads and launches against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (rd_q.size() == 0) begin
                check(1'b0, cur_req, "read without expectation", 32'(rd_data), 32'hx);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check(rd_data === it.val, it.req, "rd_data", 32'(rd_data), 32'(it.val));
            end
        end
        if (rst_n && prog_start) begin
            if (st_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected start", 32'(prog_addr), 32'h0);
            end else begin
                st_item_t si;
                si = st_q.pop_front();
                check(prog_addr === si.addr, si.req, "prog_addr", 32'(prog_addr), 32'(si.addr));
                check(prog_data === si.data, si.req, "prog_data", 32'(prog_data), 32'(si.data));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        rd_item_t it;
        @(posedge clk); #1;
        it.val = exp; it.req = req;
        rd_q.push_back(it);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic expect_start(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        st_item_t si;
        si.addr = a; si.data = d; si.req = req;
        st_q.push_back(si);
    endtask

    task automatic chk_mode(input logic [1:0] exp, input string req);
        @(negedge clk);
        check(mode === exp, req, "mode", 32'(mode), 32'(exp));
    endtask

    task automatic unlock();
        wr(21'h00555, 16'h00AA);
        wr(21'h002AA, 16'h0055);
    endtask

    task automatic engine_run(input int n);
        @(posedge clk); #1;
        eng_busy = 1'b1;
        repeat (n) @(posedge clk);
        #1 eng_busy = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, cur_req, "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        chk_mode(2'd0, "R1");
        check(!prog_start && !prog_abort && !multi_handoff, "R1", "pulses idle", 32'h0, 32'h0);
        rd(21'h00123, 16'h5B79, "R1");

        // R2 program, R8 status during programming, R12 upper bits carried
        cur_req = "R2";
        unlock();
        wr(21'h00555, 16'h00A0);
        expect_start(21'h1ABCD, 16'h1234, "R2");
        wr(21'h1ABCD, 16'h1234);
        chk_mode(2'd2, "R2");
        cur_req = "R8";
        rd(21'h00000, 16'h0080, "R8");
        rd(21'h00000, 16'h00C0, "R8");
        wr(21'h00000, 16'h00F0);
        chk_mode(2'd2, "R8");
        engine_run(3);
        chk_mode(2'd0, "R2");

        // R3 identify codes
        cur_req = "R3";
        unlock();
        wr(21'h00555, 16'h0090);
        chk_mode(2'd1, "R3");
        rd(21'h1FFFC, 16'h0020, "R3");
        rd(21'h00001, 16'h888E, "R3");
        rd(21'h00002, 16'h0000, "R3");

        // R7 program code ignored in identify
        cur_req = "R7";
        unlock();
        wr(21'h00555, 16'h00A0);
        wr(21'h00200, 16'h0000);
        chk_mode(2'd1, "R7");
        // R4 single-write reset
        cur_req = "R4";
        wr(21'h00777, 16'h00F0);
        chk_mode(2'd0, "R4");

        // R4 reset inside a sequence, then the rest must not launch
        wr(21'h00555, 16'h00AA);
        wr(21'h00123, 16'h00F0);
        wr(21'h002AA, 16'h0055);
        wr(21'h00555, 16'h00A0);
        wr(21'h00300, 16'h0000);
        chk_mode(2'd0, "R4");
        // R4 three-write reset out of identify
        unlock();
        wr(21'h00555, 16'h0090);
        chk_mode(2'd1, "R4");
        unlock();
        wr(21'h00042, 16'h00F0);
        chk_mode(2'd0, "R4");

        // R5 broken sequence
        cur_req = "R5";
        unlock();
        wr(21'h00556, 16'h00A0);
        wr(21'h00300, 16'h00FF);
        chk_mode(2'd0, "R5");

        // R6 supply low
        cur_req = "R6";
        hv_ok = 1'b0;
        unlock();
        wr(21'h00555, 16'h00A0);
        wr(21'h00300, 16'h0000);
        chk_mode(2'd0, "R6");
        hv_ok = 1'b1;
        unlock();
        hv_ok = 1'b0;
        wr(21'h00555, 16'h0090);
        hv_ok = 1'b1;
        chk_mode(2'd0, "R6");
        unlock();
        hv_ok = 1'b0;
        wr(21'h00555, 16'h00A0);
        hv_ok = 1'b1;
        wr(21'h00300, 16'h0000);
        chk_mode(2'd0, "R6");

        // R12 upper bits ignored in decode
        cur_req = "R12";
        wr(21'h1F555, 16'h77AA);
        wr(21'h0A2AA, 16'h3355);
        wr(21'h10555, 16'hFF90);
        chk_mode(2'd1, "R12");
        wr(21'h00000, 16'hABF0);
        chk_mode(2'd0, "R12");

        // R9 attempt to set a cleared bit
        cur_req = "R9";
        unlock();
        wr(21'h00555, 16'h00A0);
        expect_start(21'h00100, 16'h000F, "R9");
        wr(21'h00100, 16'h00FF);
        engine_run(2);
        chk_mode(2'd3, "R9");
        rd(21'h00100, 16'h00A0, "R9");
        rd(21'h00100, 16'h00E0, "R10");

        // R10 error holds until reset
        cur_req = "R10";
        unlock();
        wr(21'h00555, 16'h00A0);
        wr(21'h00300, 16'h0000);
        chk_mode(2'd3, "R10");
        rd(21'h00000, 16'h00A0, "R10");
        unlock();
        wr(21'h00000, 16'h00F0);
        chk_mode(2'd0, "R10");

        // R11 supply loss during programming
        cur_req = "R11";
        unlock();
        wr(21'h00555, 16'h00A0);
        expect_start(21'h00400, 16'h1280, "R11");
        wr(21'h00400, 16'h1280);
        @(posedge clk); #1;
        eng_busy = 1'b1; hv_ok = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(mode === 2'd3 && prog_abort === 1'b1, "R11", "abort", 32'({mode, prog_abort}), 32'h7);
        rd(21'h00000, 16'h0030, "R11");
        @(posedge clk); #1;
        hv_ok = 1'b1; eng_busy = 1'b0;
        wr(21'h00000, 16'h00F0);
        chk_mode(2'd0, "R11");
        rd(21'h00005, 16'h5A5F, "R11");

        // R13 multi-word hand-over
        cur_req = "R13";
        unlock();
        wr(21'h00555, 16'h0020);
        @(negedge clk);
        check(multi_handoff === 1'b1 && mode === 2'd0, "R13", "handoff",
              32'({mode, multi_handoff}), 32'h1);
        @(negedge clk);
        check(multi_handoff === 1'b0, "R13", "handoff pulse width", 32'(multi_handoff), 32'h0);

        repeat (2) @(posedge clk);
        check(st_q.size() == 0, "R2", "launches outstanding", 32'(st_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule